// File: doc/BRIEF.md
# Dual-Bank Wavetable Voice

This block is one voice of a sound generator that plays back a short, user-loaded waveform. It holds two banks of sixteen bytes each. Every byte holds two 4-bit samples, so each bank is a 32-sample cycle. An 11-bit frequency value sets how many input clock ticks each sample is held. The 4-bit sample at the current position is scaled by a volume setting and sent out as a 4-bit level. Turning that level into an analogue voltage happens outside this block.

Software writes three control registers: control-low, control-high and frequency/trigger. It also has byte access to the wave storage, but only to the bank that is not playing. This lets a new waveform be loaded while the other bank sounds. A chaining mode joins both banks into one 64-sample loop. A separate length block watches the length-enable flag exported here and pulls `kill` to stop the voice. Pulling `rst_n` low is the power-off: every register returns to its idle value, and both banks keep their contents.

Top module: `wave_voice`

## Requirements
- R1: While active, the position advances once every (2048 − freq) × 8 cycles in which `tick` is high. Cycles with `tick` low do not count. freq is bits 10..0 of the frequency write.
- R2: With chaining off (control-low bit 5 = 0), positions run 0..31 and then wrap to 0, all read from the playing bank.
- R3: With chaining on (control-low bit 5 = 1), positions run 0..63. Positions 0..31 read the playing bank, 32..63 read the other bank, and the count then wraps to 0.
- R4: Position p reads byte p/2 of its bank. An even p takes bits 7..4 and an odd p takes bits 3..0.
- R5: In control-low, bit 6 picks the playing bank and bit 7 enables the DAC. Writing control-low with bit 7 clear drops `active` at the next edge.
- R6: The level field is control-high bits 14..13. Code 0 outputs 0, code 1 outputs the sample, code 2 outputs the sample shifted right by 1, and code 3 outputs it shifted right by 2.
- R7: When control-high bit 15 is set, the output is floor(sample × 3 / 4), whatever the level field holds.
- R8: A frequency write with bit 15 set is a trigger. It sets `active` to the DAC-enable state, resets the position to 0, restarts the period, and loads bits 7..4 of byte 0 of the playing bank as the current sample.
- R9: CPU reads and writes at offsets 0..15 reach the non-playing bank, unrotated. Reads at offsets 16..31 return 0xFF. Writes at offsets 16..31 change nothing.
- R10: Reset clears every control field, the position, the sample and `active`. The contents of both banks are kept.
- R11: `level_out` is 0 whenever `active` or `dac_en` is low. Re-enabling the DAC does not reactivate the voice without a trigger.
- R12: Every frequency write copies its bit 14 to `len_en`.
- R13: With chaining off, the 0..31 mask is applied when the position advances. A position above 31, left over from chained play, folds back into the playing bank.
- R14: A high `kill` clears `active` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / power-off |
| tick | input | 1 | Clock enable for the period timer |
| kill | input | 1 | Stop request from the length block |
| ctl_lo_we | input | 1 | Control-low write strobe |
| ctl_lo_data | input | 8 | Control-low data: bit 5 chain, bit 6 bank, bit 7 DAC |
| ctl_hi_we | input | 1 | Control-high write strobe |
| ctl_hi_data | input | 16 | Control-high data: bits 14..13 level, bit 15 force 3/4 |
| freq_we | input | 1 | Frequency write strobe |
| freq_data | input | 16 | Bits 10..0 freq, bit 14 length enable, bit 15 trigger |
| mem_we | input | 1 | Wave storage write strobe |
| mem_addr | input | 5 | Wave storage byte offset |
| mem_wdata | input | 8 | Wave storage write data |
| mem_rdata | output | 8 | Wave storage read data (combinational) |
| level_out | output | 4 | Volume-scaled sample |
| active | output | 1 | Voice is playing |
| dac_en | output | 1 | DAC enable state |
| len_en | output | 1 | Length enable passed to the length block |

## Verification
The bench goes after four corner cases.

- **Fold-back on leaving chained mode.** It plays chained up to position 40 and then turns chaining off. A design that masks only on a wrap at 31, instead of on every advance, would keep reading the other bank.
- **Period length.** It checks the exact edge on which the position advances at two frequencies, and with `tick` held low. An off-by-one timer would move one cycle early or late, and a timer that ignores `tick` would run ahead.
- **Out-of-range offsets.** It writes and reads at offsets 16..31. A design that decodes only four address bits would corrupt bytes 0..15 and return stored data instead of 0xFF.
- **Volume scaling.** It checks each level code and the 3/4 override on samples where truncation matters, such as 1 and 7. Scaling with the wrong rounding, or letting the level field win over the override, would give the wrong level.

// File: rtl/wv_pkg.sv
// Package of shared widths and the level-code encoding for the wavetable voice.
// Assumes 4-bit samples packed two per byte.
package wv_pkg;
    localparam int WV_FREQ_W     = 11;
    localparam int WV_SAMPLE_W   = 4;
    localparam int WV_BANK_BYTES = 16;
    localparam int WV_CPU_ADDR_W = 5;
    localparam int WV_STEP_SHIFT = 3;   // period multiplier of 8

    typedef enum logic [1:0] {
        LVL_MUTE    = 2'd0,
        LVL_FULL    = 2'd1,
        LVL_HALF    = 2'd2,
        LVL_QUARTER = 2'd3
    } wv_level_e;
endpackage

// File: rtl/wv_step_timer.sv
// Period timer: produces a one-cycle step pulse every ((2^FREQ_W) - freq) << STEP_SHIFT
// ticks while run is high. A load restarts the full period and suppresses a step.
// Assumes freq is stable between loads (a new value is used on the next reload).
module wv_step_timer #(
    parameter int FREQ_W     = 11,
    parameter int STEP_SHIFT = 3,
    localparam int TIMER_W   = FREQ_W + 1 + STEP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              load,
    input  logic [FREQ_W-1:0] freq,
    output logic              step
);
    localparam int SPAN = 1 << FREQ_W;

    logic [FREQ_W:0]    span_left;
    logic [TIMER_W-1:0] period;
    logic [TIMER_W-1:0] cnt_q;

    // Period length in ticks derived from the frequency value.
    always_comb begin
        span_left = (FREQ_W+1)'(SPAN) - {1'b0, freq};
        period    = {span_left, STEP_SHIFT'(0)};
    end

    // Step fires on the last tick of a period.
    assign step = run && tick && !load && (cnt_q <= TIMER_W'(1));

    // Down-counter reloaded on trigger and at the end of every period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (run && tick) begin
            cnt_q <= (cnt_q <= TIMER_W'(1)) ? period : cnt_q - TIMER_W'(1);
        end
    end
endmodule

// File: rtl/wv_bank_store.sv
// Two-bank byte storage. The CPU port always reaches the bank not selected for play;
// offsets at or above BANK_BYTES read as all ones and ignore writes.
// The playback port reads any bank/byte combinationally. Contents have no reset.
module wv_bank_store #(
    parameter int BANK_BYTES = 16,
    parameter int ADDR_W     = 5,
    parameter int BYTE_W     = 8,
    localparam int IDX_W     = $clog2(BANK_BYTES),
    localparam int NUM_BANKS = 2
) (
    input  logic              clk,
    input  logic              play_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_byte
);
    logic                               in_range;
    logic [IDX_W-1:0]                   cpu_idx;
    logic [NUM_BANKS-1:0][BYTE_W-1:0]   cpu_view;
    logic [NUM_BANKS-1:0][BYTE_W-1:0]   play_view;

    assign in_range = (cpu_addr < ADDR_W'(BANK_BYTES));
    assign cpu_idx  = cpu_addr[IDX_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BYTE_W-1:0] store [BANK_BYTES];

        // CPU write lands only in the bank that is not playing.
        always_ff @(posedge clk) begin
            if (cpu_we && in_range && (1'(b) != play_sel)) begin
                store[cpu_idx] <= cpu_wdata;
            end
        end

        assign cpu_view[b]  = store[cpu_idx];
        assign play_view[b] = store[rd_idx];
    end

    // CPU read of the non-playing bank, all ones outside the bank.
    assign cpu_rdata = in_range ? cpu_view[~play_sel] : {BYTE_W{1'b1}};
    // Playback read of the requested bank.
    assign rd_byte   = play_view[rd_bank];
endmodule

// File: rtl/wv_level_scale.sv
// Volume scaler: applies the 2-bit shift level or the 3/4 override to a sample,
// and forces zero when the voice is not enabled. Purely combinational.
module wv_level_scale
    import wv_pkg::*;
#(
    parameter int SAMPLE_W = 4
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  wv_level_e           level,
    input  logic                force34,
    input  logic                enable,
    output logic [SAMPLE_W-1:0] scaled
);
    logic [SAMPLE_W+1:0] triple;

    // Pick the override or the shift selected by the level code.
    always_comb begin
        triple = {2'b00, sample} * (SAMPLE_W+2)'(3);
        if (!enable) begin
            scaled = '0;
        end else if (force34) begin
            scaled = triple[SAMPLE_W+1:2];
        end else begin
            unique case (level)
                LVL_MUTE:    scaled = '0;
                LVL_FULL:    scaled = sample;
                LVL_HALF:    scaled = sample >> 1;
                LVL_QUARTER: scaled = sample >> 2;
                default:     scaled = '0;
            endcase
        end
    end
endmodule

// File: rtl/wave_voice.sv
// Dual-bank wavetable voice: control registers, play position and current sample,
// built on a period timer, a two-bank store and a level scaler.
// Assumes register writes and trigger do not coincide with a kill from the length block
// (kill and DAC-off win if they do). rst_n doubles as power-off; bank contents survive it.
module wave_voice
    import wv_pkg::*;
#(
    parameter int FREQ_W     = WV_FREQ_W,
    parameter int SAMPLE_W   = WV_SAMPLE_W,
    parameter int BANK_BYTES = WV_BANK_BYTES,
    parameter int CPU_ADDR_W = WV_CPU_ADDR_W,
    localparam int BYTE_W    = 2 * SAMPLE_W,
    localparam int IDX_W     = $clog2(BANK_BYTES),
    localparam int POS_W     = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  kill,
    input  logic                  ctl_lo_we,
    input  logic [7:0]            ctl_lo_data,
    input  logic                  ctl_hi_we,
    input  logic [15:0]           ctl_hi_data,
    input  logic                  freq_we,
    input  logic [15:0]           freq_data,
    input  logic                  mem_we,
    input  logic [CPU_ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0]     mem_wdata,
    output logic [BYTE_W-1:0]     mem_rdata,
    output logic [SAMPLE_W-1:0]   level_out,
    output logic                  active,
    output logic                  dac_en,
    output logic                  len_en
);
    logic              chain_q, sel_q, dac_q, force_q, len_q, active_q;
    wv_level_e         level_q;
    logic [FREQ_W-1:0] freq_q;
    logic [POS_W-1:0]  pos_q, pos_inc, pos_next;
    logic [SAMPLE_W-1:0] sample_q, pick;
    logic              trig, step, dac_off_wr;
    logic              rd_bank;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    logic              unused_bits;

    assign unused_bits = ^{ctl_lo_data[4:0], ctl_hi_data[12:0], freq_data[13:FREQ_W]};

    assign trig       = freq_we && freq_data[15];
    assign dac_off_wr = ctl_lo_we && !ctl_lo_data[7];

    // Control register capture from the three write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= 1'b0;
            sel_q   <= 1'b0;
            dac_q   <= 1'b0;
            level_q <= LVL_MUTE;
            force_q <= 1'b0;
            freq_q  <= '0;
            len_q   <= 1'b0;
        end else begin
            if (ctl_lo_we) begin
                chain_q <= ctl_lo_data[5];
                sel_q   <= ctl_lo_data[6];
                dac_q   <= ctl_lo_data[7];
            end
            if (ctl_hi_we) begin
                level_q <= wv_level_e'(ctl_hi_data[14:13]);
                force_q <= ctl_hi_data[15];
            end
            if (freq_we) begin
                freq_q <= freq_data[FREQ_W-1:0];
                len_q  <= freq_data[14];
            end
        end
    end

    // Active flag: set by trigger from the DAC state, cleared by kill or DAC off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (kill || dac_off_wr) begin
            active_q <= 1'b0;
        end else if (trig) begin
            active_q <= dac_q;
        end
    end

    wv_step_timer #(
        .FREQ_W     (FREQ_W),
        .STEP_SHIFT (WV_STEP_SHIFT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (active_q),
        .load  (trig),
        .freq  (trig ? freq_data[FREQ_W-1:0] : freq_q),
        .step  (step)
    );

    // Next position, masked to one bank at the moment of advance unless chained.
    always_comb begin
        pos_inc  = pos_q + POS_W'(1);
        pos_next = chain_q ? pos_inc : {1'b0, pos_inc[POS_W-2:0]};
    end

    // Playback read address: byte 0 of the playing bank on trigger, else next position.
    always_comb begin
        rd_bank = trig ? sel_q : (sel_q ^ pos_next[POS_W-1]);
        rd_idx  = trig ? '0 : pos_next[POS_W-2:1];
        pick    = (!trig && pos_next[0]) ? rd_byte[SAMPLE_W-1:0]
                                         : rd_byte[BYTE_W-1:SAMPLE_W];
    end

    // Position and current sample update on trigger or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            sample_q <= '0;
        end else if (trig) begin
            pos_q    <= '0;
            sample_q <= pick;
        end else if (step) begin
            pos_q    <= pos_next;
            sample_q <= pick;
        end
    end

    wv_bank_store #(
        .BANK_BYTES (BANK_BYTES),
        .ADDR_W     (CPU_ADDR_W),
        .BYTE_W     (BYTE_W)
    ) u_store (
        .clk       (clk),
        .play_sel  (sel_q),
        .cpu_we    (mem_we),
        .cpu_addr  (mem_addr),
        .cpu_wdata (mem_wdata),
        .cpu_rdata (mem_rdata),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_byte)
    );

    wv_level_scale #(
        .SAMPLE_W (SAMPLE_W)
    ) u_scale (
        .sample  (sample_q),
        .level   (level_q),
        .force34 (force_q),
        .enable  (active_q && dac_q),
        .scaled  (level_out)
    );

    assign active = active_q;
    assign dac_en = dac_q;
    assign len_en = len_q;
endmodule

// File: rtl/wv_checker.sv
// Property checker for wave_voice, attached by bind. Observes ports and the play position.
module wv_checker #(
    parameter int SAMPLE_W   = 4,
    parameter int CPU_ADDR_W = 5,
    parameter int BANK_BYTES = 16,
    parameter int POS_W      = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  kill,
    input logic                  ctl_lo_we,
    input logic                  ctl_lo_dac,
    input logic                  freq_we,
    input logic                  freq_trig,
    input logic                  freq_len,
    input logic [CPU_ADDR_W-1:0] mem_addr,
    input logic [7:0]            mem_rdata,
    input logic [SAMPLE_W-1:0]   level_out,
    input logic                  active,
    input logic                  dac_en,
    input logic                  len_en,
    input logic [POS_W-1:0]      pos_q
);
    a_r11_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || !dac_en) |-> (level_out == '0));

    a_r5_dac_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lo_we && !ctl_lo_dac) |=> (!active && !dac_en));

    a_r14_kill_stops: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !active);

    a_r8_trigger_follows_dac: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_we && freq_trig && !kill && !ctl_lo_we) |=> (active == $past(dac_en) && pos_q == '0));

    a_r8_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(freq_we && freq_trig));

    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(freq_we && freq_trig)) |=> $stable(pos_q));

    a_r12_len_copy: assert property (@(posedge clk) disable iff (!rst_n)
        freq_we |=> (len_en == $past(freq_len)));

    a_r9_high_offset_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >= CPU_ADDR_W'(BANK_BYTES)) |-> (mem_rdata == 8'hFF));
endmodule

bind wave_voice wv_checker #(
    .SAMPLE_W   (SAMPLE_W),
    .CPU_ADDR_W (CPU_ADDR_W),
    .BANK_BYTES (BANK_BYTES),
    .POS_W      (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .kill       (kill),
    .ctl_lo_we  (ctl_lo_we),
    .ctl_lo_dac (ctl_lo_data[7]),
    .freq_we    (freq_we),
    .freq_trig  (freq_data[15]),
    .freq_len   (freq_data[14]),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .level_out  (level_out),
    .active     (active),
    .dac_en     (dac_en),
    .len_en     (len_en),
    .pos_q      (pos_q)
);

// File: tb/wave_voice_tb.sv
// Self-checking bench for wave_voice: a scaling vector table, then directed tests.
module wave_voice_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        kill = 1'b0;
    logic        ctl_lo_we = 1'b0;
    logic [7:0]  ctl_lo_data = '0;
    logic        ctl_hi_we = 1'b0;
    logic [15:0] ctl_hi_data = '0;
    logic        freq_we = 1'b0;
    logic [15:0] freq_data = '0;
    logic        mem_we = 1'b0;
    logic [4:0]  mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  mem_rdata;
    logic [3:0]  level_out;
    logic        active, dac_en, len_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t0     = 0;
    logic [7:0] bk0 [16];
    logic [7:0] bk1 [16];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    wave_voice u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kill(kill),
        .ctl_lo_we(ctl_lo_we), .ctl_lo_data(ctl_lo_data),
        .ctl_hi_we(ctl_hi_we), .ctl_hi_data(ctl_hi_data),
        .freq_we(freq_we), .freq_data(freq_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .level_out(level_out), .active(active), .dac_en(dac_en), .len_en(len_en)
    );

    // Scaling vectors: {sample, force, level code, pad, expected output}.
    localparam logic [15:0] VEC [8] = '{
        {4'd15, 1'b0, 2'd1, 5'd0, 4'd15},
        {4'd15, 1'b0, 2'd2, 5'd0, 4'd7},
        {4'd15, 1'b0, 2'd3, 5'd0, 4'd3},
        {4'd15, 1'b0, 2'd0, 5'd0, 4'd0},
        {4'd12, 1'b1, 2'd3, 5'd0, 4'd9},
        {4'd1,  1'b1, 2'd0, 5'd0, 4'd0},
        {4'd9,  1'b0, 2'd2, 5'd0, 4'd4},
        {4'd7,  1'b1, 2'd0, 5'd0, 4'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_lo(input logic [7:0] d);
        ctl_lo_data = d; ctl_lo_we = 1'b1;
        @(negedge clk); ctl_lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [15:0] d);
        ctl_hi_data = d; ctl_hi_we = 1'b1;
        @(negedge clk); ctl_hi_we = 1'b0;
    endtask

    task automatic wr_freq(input logic [15:0] d);
        freq_data = d; freq_we = 1'b1;
        @(negedge clk); freq_we = 1'b0;
        t0 = cyc;
    endtask

    task automatic wr_mem(input logic [4:0] a, input logic [7:0] d);
        mem_addr = a; mem_wdata = d; mem_we = 1'b1;
        @(negedge clk); mem_we = 1'b0;
    endtask

    task automatic rd_mem(input logic [4:0] a, output logic [7:0] d);
        mem_addr = a; #1; d = mem_rdata;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc - t0 < n) @(negedge clk);
    endtask

    // Position k of an 8-tick period is sampled mid-way through its interval.
    task automatic wait_pos(input int k);
        wait_cyc(8 * k + 4);
    endtask

    function automatic logic [3:0] exp_samp(input bit bank, input int pos);
        logic [7:0] b;
        b = bank ? bk1[pos / 2] : bk0[pos / 2];
        return (pos % 2 == 1) ? b[3:0] : b[7:4];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 200000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 16; i++) begin
            bk0[i] = {4'(i), 4'(15 - i)};
            bk1[i] = {4'(i) ^ 4'h5, 4'(i) ^ 4'hA};
        end
        repeat (3) @(negedge clk);
        // R10: idle state under reset
        chk("R10 active after reset", int'(active), 0);
        chk("R10 dac after reset", int'(dac_en), 0);
        chk("R10 level after reset", int'(level_out), 0);
        chk("R12 len_en after reset", int'(len_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Load both banks through the CPU port (R9: CPU reaches the non-playing bank)
        wr_lo(8'h40);
        for (int i = 0; i < 16; i++) wr_mem(5'(i), bk0[i]);
        wr_lo(8'h00);
        for (int i = 0; i < 16; i++) wr_mem(5'(i), bk1[i]);
        rd_mem(5'd5, rd);  chk("R9 read non-playing bank", int'(rd), int'(bk1[5]));
        rd_mem(5'd16, rd); chk("R9 read offset 16", int'(rd), 255);
        wr_mem(5'd17, 8'h00);
        rd_mem(5'd1, rd);  chk("R9 write offset 17 ignored", int'(rd), int'(bk1[1]));
        rd_mem(5'd31, rd); chk("R9 read offset 31", int'(rd), 255);
        wr_lo(8'h40);
        rd_mem(5'd1, rd);  chk("R9 other bank untouched", int'(rd), int'(bk0[1]));

        // Vector table: level codes and the 3/4 override (R6, R7, R8)
        foreach (VEC[v]) begin
            wr_lo(8'h80);
            wr_mem(5'd0, {VEC[v][15:12], 4'h0});
            bk1[0] = {VEC[v][15:12], 4'h0};
            wr_lo(8'hC0);
            wr_hi({VEC[v][11], VEC[v][10:9], 13'd0});
            wr_freq(16'h8000 | 16'd2047);
            chk("R8 trigger sets active", int'(active), 1);
            chk("R6/R7 scaled level", int'(level_out), int'(VEC[v][3:0]));
        end

        // Single-bank sweep over 34 positions (R2, R4)
        wr_hi(16'h2000);
        wr_lo(8'h80);
        wr_freq(16'h8000 | 16'd2047);
        for (int k = 0; k < 34; k++) begin
            wait_pos(k);
            chk("R2/R4 single-bank sample", int'(level_out), int'(exp_samp(1'b0, k % 32)));
        end

        // Chained sweep, bank 0 playing (R3)
        wr_lo(8'hA0);
        wr_freq(16'h8000 | 16'd2047);
        for (int k = 0; k < 66; k++) begin
            wait_pos(k);
            chk("R3 chained sample", int'(level_out),
                int'(exp_samp((k % 64) >= 32, k % 32)));
        end

        // Chained, bank 1 playing (R3, R5 bank select)
        wr_lo(8'hE0);
        wr_freq(16'h8000 | 16'd2047);
        wait_pos(0);  chk("R3 sel1 pos0", int'(level_out), int'(exp_samp(1'b1, 0)));
        wait_pos(32); chk("R3 sel1 pos32", int'(level_out), int'(exp_samp(1'b0, 0)));
        wait_pos(33); chk("R3 sel1 pos33", int'(level_out), int'(exp_samp(1'b0, 1)));

        // Fold-back when chaining is turned off at position 40 (R13)
        wr_lo(8'hA0);
        wr_freq(16'h8000 | 16'd2047);
        wait_pos(40); chk("R13 chained pos40", int'(level_out), int'(exp_samp(1'b1, 8)));
        wr_lo(8'h80);
        wait_pos(41); chk("R13 fold to pos9", int'(level_out), int'(exp_samp(1'b0, 9)));
        wait_pos(42); chk("R13 fold pos10", int'(level_out), int'(exp_samp(1'b0, 10)));

        // Period length at freq 2046: 16 ticks per step (R1)
        wr_freq(16'h8000 | 16'd2046);
        wait_cyc(15); chk("R1 still pos0 at 15", int'(level_out), int'(exp_samp(1'b0, 0)));
        wait_cyc(16); chk("R1 pos1 at 16", int'(level_out), int'(exp_samp(1'b0, 1)));

        // Tick gating (R1)
        tick = 1'b0;
        wr_freq(16'h8000 | 16'd2047);
        wait_cyc(40); chk("R1 no advance without tick", int'(level_out), int'(exp_samp(1'b0, 0)));
        tick = 1'b1;
        t0 = cyc;
        wait_cyc(7); chk("R1 pos0 after 7 ticks", int'(level_out), int'(exp_samp(1'b0, 0)));
        wait_cyc(8); chk("R1 pos1 after 8 ticks", int'(level_out), int'(exp_samp(1'b0, 1)));

        // DAC off stops the voice; re-enable needs a trigger (R5, R11, R8)
        wr_lo(8'h00);
        chk("R5 dac clear drops active", int'(active), 0);
        chk("R11 level zero with dac off", int'(level_out), 0);
        wr_lo(8'h80);
        chk("R11 dac on alone keeps inactive", int'(active), 0);
        chk("R5 dac flag", int'(dac_en), 1);
        chk("R11 level still zero", int'(level_out), 0);
        wr_freq(16'h8000 | 16'd2047);
        chk("R8 retrigger active", int'(active), 1);
        wr_lo(8'h00);
        wr_freq(16'h8000 | 16'd2047);
        chk("R8 trigger with dac off", int'(active), 0);

        // Kill from the length block (R14)
        wr_lo(8'h80);
        wr_freq(16'h8000 | 16'd2047);
        kill = 1'b1; @(negedge clk); kill = 1'b0;
        chk("R14 kill drops active", int'(active), 0);
        chk("R14 level zero after kill", int'(level_out), 0);

        // Length enable export (R12)
        wr_freq(16'h4000 | 16'd2047);
        chk("R12 len_en set", int'(len_en), 1);
        wr_freq(16'd2047);
        chk("R12 len_en clear", int'(len_en), 0);

        // Power-off keeps bank contents (R10)
        wr_lo(8'hC0);
        wr_freq(16'h8000 | 16'd2047);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 active cleared", int'(active), 0);
        chk("R10 dac cleared", int'(dac_en), 0);
        rd_mem(5'd3, rd); chk("R10 bank1 kept, sel reset", int'(rd), int'(bk1[3]));
        wr_lo(8'h40);
        rd_mem(5'd3, rd); chk("R10 bank0 kept", int'(rd), int'(bk0[3]));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule